// File: doc/BRIEF.md
# Dual-CPU Shared RAM Arbiter

This block sits between two CPU buses and a single 2 KiB RAM that both of them can address in the window $6000-$7FFF. At any time exactly one CPU owns the RAM. The CPU that does not own it gets no response there: its reads hand back whatever value its own bus last carried, and its writes are dropped. Ownership follows one control bit, bit 1 of a write to $4016, and only the primary CPU's copy of that bit decides. The same bit, on each side, also drives the other CPU's interrupt request as an active-low line. This gives the two programs both a mutex-like handover of the RAM and a doorbell interrupt.

A read of $4016 returns an identity byte. Bit 7 tells the program which socket it runs in, and the other bits are left at 0 for neighbouring logic to fill. A strap input models a jumper that occupies the primary socket of a single-CPU machine. The strap holds the primary control bit low at all times. As a result the remaining CPU (the secondary) has the RAM to itself, and its interrupt input is held asserted.

Each port's read data comes from a per-port bus-value register. That register is loaded on every write with the write data, and on every serviced read with the result.

Top module: `shram_arbiter`

## Requirements
- R1: A CPU that owns the RAM reads and writes it at any address whose top three bits are 011 ($6000-$7FFF), indexed by address bits 10:0, so the 2 KiB appear four times in the window; the read result shows on that port's read data one cycle after the request.
- R2: When the primary control bit is 1 (and the strap is 0), the primary CPU owns the RAM and the secondary CPU's RAM accesses are not serviced.
- R3: When the primary control bit is 0, the secondary CPU owns the RAM and the primary CPU's RAM accesses are not serviced.
- R4: Writing the secondary control bit changes nothing about ownership.
- R5: Each CPU's control bit (bit 1 of a write to address $4016) drives the other CPU's IRQ output: priIrqN equals the secondary bit and secIrqN equals the effective primary bit, so 0 asserts and 1 releases.
- R6: A read of $4016 returns 8'h00 on the primary port and 8'h80 on the secondary port, one cycle later.
- R7: With strapSolo at 1, the effective primary control bit is 0 in the same cycle: the secondary CPU owns the RAM and secIrqN is 0, whatever the primary wrote.
- R8: A non-owner's read leaves its read data at its last bus value, which is the last data it wrote or the last result it was given. A non-owner's write stores its data in that bus value but never reaches the RAM.
- R9: Reset clears both control bits and both read-data registers to 0, so after reset the secondary CPU owns the RAM and both IRQ outputs are 0.
- R10: A control write takes effect on the following cycle. A RAM access made by either CPU in the same cycle as the control write is judged against the ownership that held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapSolo | input | 1 | Single-CPU jumper: forces the primary control bit low |
| priAddr | input | 16 | Primary CPU address |
| priWrEn | input | 1 | Primary write request, one cycle |
| priRdEn | input | 1 | Primary read request, one cycle |
| priWrData | input | 8 | Primary write data |
| priRdData | output | 8 | Primary read data / last bus value |
| priIrqN | output | 1 | Active-low IRQ to the primary CPU |
| secAddr | input | 16 | Secondary CPU address |
| secWrEn | input | 1 | Secondary write request, one cycle |
| secRdEn | input | 1 | Secondary read request, one cycle |
| secWrData | input | 8 | Secondary write data |
| secRdData | output | 8 | Secondary read data / last bus value |
| secIrqN | output | 1 | Active-low IRQ to the secondary CPU |

## Verification
The ownership handover and a RAM access can fall in the same cycle. This happens when the primary CPU writes its control bit while the secondary CPU writes or reads the window. The bench drives both ports in one cycle, in both directions of the handover. It judges the result by whether the RAM took the secondary write, checked afterwards through a primary read. It also checks whether the secondary read returned RAM data or only its previous bus value.

// File: rtl/shram_pkg.sv
package shram_pkg;
  localparam int RAM_AW = 11;
  localparam int DATA_W = 8;
  localparam int CPU_AW = 16;
  localparam int CPU_N  = 2;
  localparam int PRI    = 0;
  localparam int SEC    = 1;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic              ramWr;    // write the RAM with the owner's data
    logic              ramSel;   // which port owns the RAM (1 = secondary)
    logic [RAM_AW-1:0] ramAddr;  // RAM index from the owner's address
    logic [CPU_N-1:0]  takeWr;   // load bus value from own write data
    logic [CPU_N-1:0]  takeRam;  // load bus value from RAM read
    logic [CPU_N-1:0]  takeId;   // load bus value with identity byte
  } arbStrobe_t;
endpackage

// File: rtl/shram_ctrl.sv
module shram_ctrl
  import shram_pkg::*;
#(
  parameter logic [CPU_AW-1:0] CTRL_ADDR = 16'h4016,
  parameter logic [2:0]        WIN_TAG   = 3'b011,
  parameter int                CTRL_BIT  = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         strapSolo,
  input  logic [CPU_N-1:0][CPU_AW-1:0] addr,
  input  logic [CPU_N-1:0]             wrEn,
  input  logic [CPU_N-1:0]             rdEn,
  input  logic [CPU_N-1:0][DATA_W-1:0] wrData,
  output arbStrobe_t                   strobe,
  output logic                         priIrqN,
  output logic                         secIrqN
);
  localparam int TAG_W = 3;

  logic [CPU_N-1:0] ctrlQ;
  logic [CPU_N-1:0] inWin;
  logic [CPU_N-1:0] isCtrl;
  logic [CPU_N-1:0] ctrlWr;
  logic [CPU_N-1:0] ramReq;
  logic             priEff;
  logic             owner;

  for (genvar i = 0; i < CPU_N; i++) begin : g_dec
    assign inWin[i]  = (addr[i][CPU_AW-1 -: TAG_W] == WIN_TAG);
    assign isCtrl[i] = (addr[i] == CTRL_ADDR);
    assign ctrlWr[i] = wrEn[i] && isCtrl[i];
    assign ramReq[i] = (wrEn[i] || rdEn[i]) && inWin[i];

    always_ff @(posedge clk) begin
      if (!rstN)          ctrlQ[i] <= 1'b0;
      else if (ctrlWr[i]) ctrlQ[i] <= wrData[i][CTRL_BIT];
    end
  end

  // strap grounds the primary side's bit; only that side arbitrates
  assign priEff = ctrlQ[PRI] && !strapSolo;
  assign owner  = !priEff;   // 1 = secondary owns

  assign priIrqN = ctrlQ[SEC];
  assign secIrqN = priEff;

  always_comb begin
    strobe         = '0;
    strobe.ramSel  = owner;
    strobe.ramAddr = owner ? addr[SEC][RAM_AW-1:0] : addr[PRI][RAM_AW-1:0];
    strobe.ramWr   = owner ? (wrEn[SEC] && inWin[SEC]) : (wrEn[PRI] && inWin[PRI]);
    for (int i = 0; i < CPU_N; i++) begin
      strobe.takeWr[i]  = wrEn[i];
      strobe.takeRam[i] = !wrEn[i] && rdEn[i] && ramReq[i] && (owner == (i == SEC));
      strobe.takeId[i]  = !wrEn[i] && rdEn[i] && isCtrl[i];
    end
  end
endmodule

// File: rtl/shram_datapath.sv
module shram_datapath
  import shram_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  arbStrobe_t                   strobe,
  input  logic [CPU_N-1:0][DATA_W-1:0] wrData,
  output logic [CPU_N-1:0][DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ramQ;
  logic [DATA_W-1:0] ramD;

  assign ramD = strobe.ramSel ? wrData[SEC] : wrData[PRI];
  assign ramQ = mem[strobe.ramAddr];

  // battery-backed array: no reset
  always_ff @(posedge clk) begin
    if (strobe.ramWr) mem[strobe.ramAddr] <= ramD;
  end

  for (genvar i = 0; i < CPU_N; i++) begin : g_bus
    logic [DATA_W-1:0] idByte;
    logic [DATA_W-1:0] busQ;

    always_comb begin
      idByte           = '0;
      idByte[DATA_W-1] = (i == SEC);
    end

    always_ff @(posedge clk) begin
      if (!rstN)                  busQ <= '0;
      else if (strobe.takeWr[i])  busQ <= wrData[i];
      else if (strobe.takeRam[i]) busQ <= ramQ;
      else if (strobe.takeId[i])  busQ <= idByte;
    end

    assign rdData[i] = busQ;
  end
endmodule

// File: rtl/shram_arbiter.sv
module shram_arbiter
  import shram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapSolo,
  input  logic [CPU_AW-1:0] priAddr,
  input  logic              priWrEn,
  input  logic              priRdEn,
  input  logic [DATA_W-1:0] priWrData,
  output logic [DATA_W-1:0] priRdData,
  output logic              priIrqN,
  input  logic [CPU_AW-1:0] secAddr,
  input  logic              secWrEn,
  input  logic              secRdEn,
  input  logic [DATA_W-1:0] secWrData,
  output logic [DATA_W-1:0] secRdData,
  output logic              secIrqN
);
  logic [CPU_N-1:0][CPU_AW-1:0] addrV;
  logic [CPU_N-1:0][DATA_W-1:0] wrV;
  logic [CPU_N-1:0][DATA_W-1:0] rdV;
  logic [CPU_N-1:0]             wrEnV;
  logic [CPU_N-1:0]             rdEnV;
  arbStrobe_t                   strobe;

  assign addrV = {secAddr, priAddr};
  assign wrV   = {secWrData, priWrData};
  assign wrEnV = {secWrEn, priWrEn};
  assign rdEnV = {secRdEn, priRdEn};

  shram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strapSolo(strapSolo),
    .addr(addrV), .wrEn(wrEnV), .rdEn(rdEnV), .wrData(wrV),
    .strobe(strobe), .priIrqN(priIrqN), .secIrqN(secIrqN)
  );

  shram_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrV), .rdData(rdV)
  );

  assign priRdData = rdV[PRI];
  assign secRdData = rdV[SEC];
endmodule

// File: rtl/shram_arbiter_chk.sv
module shram_arbiter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        strapSolo,
  input logic [15:0] priAddr,
  input logic        priWrEn,
  input logic        priRdEn,
  input logic [7:0]  priWrData,
  input logic [7:0]  priRdData,
  input logic        priIrqN,
  input logic [15:0] secAddr,
  input logic        secWrEn,
  input logic        secRdEn,
  input logic [7:0]  secWrData,
  input logic [7:0]  secRdData,
  input logic        secIrqN
);
  logic priWin, secWin, priCtl, secCtl;
  assign priWin = (priAddr[15:13] == 3'b011);
  assign secWin = (secAddr[15:13] == 3'b011);
  assign priCtl = (priAddr == 16'h4016);
  assign secCtl = (secAddr == 16'h4016);

  assert_sec_bit_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    (secWrEn && secCtl) |=> (priIrqN == $past(secWrData[1])));

  assert_pri_bit_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    (priWrEn && priCtl) |=> (strapSolo || secIrqN == $past(priWrData[1])));

  assert_strap_owner_R7: assert property (@(posedge clk) disable iff (!rstN)
    strapSolo |-> !secIrqN);

  assert_id_pri_R6: assert property (@(posedge clk) disable iff (!rstN)
    (priRdEn && !priWrEn && priCtl) |=> (priRdData == 8'h00));

  assert_id_sec_R6: assert property (@(posedge clk) disable iff (!rstN)
    (secRdEn && !secWrEn && secCtl) |=> (secRdData == 8'h80));

  // secIrqN high means the primary side owns the RAM
  assert_pri_openbus_R8: assert property (@(posedge clk) disable iff (!rstN)
    (priRdEn && !priWrEn && priWin && !secIrqN) |=> $stable(priRdData));

  assert_sec_openbus_R8: assert property (@(posedge clk) disable iff (!rstN)
    (secRdEn && !secWrEn && secWin && secIrqN) |=> $stable(secRdData));

  assert_sec_no_owner_R4: assert property (@(posedge clk) disable iff (!rstN)
    (secWrEn && secCtl && !(priWrEn && priCtl)) |=> ($stable(secIrqN) || !$stable(strapSolo)));
endmodule

bind shram_arbiter shram_arbiter_chk chk (.*);

// File: tb/tb_shram_arbiter.sv
module tb_shram_arbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapSolo = 1'b0;
  logic [15:0] priAddr = '0, secAddr = '0;
  logic        priWrEn = 1'b0, priRdEn = 1'b0, secWrEn = 1'b0, secRdEn = 1'b0;
  logic [7:0]  priWrData = '0, secWrData = '0;
  logic [7:0]  priRdData, secRdData;
  logic        priIrqN, secIrqN;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;   // 50 MHz

  shram_arbiter dut (.*);

  // {req[3:0], port, op[1:0] (1 write, 2 read), addr, data, expRd, expPriIrqN, expSecIrqN}
  localparam int NV = 19;
  localparam logic [40:0] VEC [NV] = '{
    {4'd3, 1'b1, 2'd1, 16'h6000, 8'hA5, 8'hA5, 1'b0, 1'b0},  // R3 secondary owns after reset
    {4'd1, 1'b1, 2'd2, 16'h6000, 8'h00, 8'hA5, 1'b0, 1'b0},  // R1 read back
    {4'd8, 1'b0, 2'd2, 16'h6000, 8'h00, 8'h00, 1'b0, 1'b0},  // R8 primary open bus
    {4'd8, 1'b0, 2'd1, 16'h6000, 8'h33, 8'h33, 1'b0, 1'b0},  // R8 write dropped, bus keeps 33
    {4'd8, 1'b1, 2'd2, 16'h6000, 8'h00, 8'hA5, 1'b0, 1'b0},  // R8 RAM unchanged
    {4'd5, 1'b0, 2'd1, 16'h4016, 8'h02, 8'h02, 1'b0, 1'b1},  // R5 primary bit releases sec IRQ
    {4'd2, 1'b0, 2'd2, 16'h6000, 8'h00, 8'hA5, 1'b0, 1'b1},  // R2 primary owns
    {4'd1, 1'b0, 2'd1, 16'h7800, 8'h5A, 8'h5A, 1'b0, 1'b1},  // R1 mirror write
    {4'd1, 1'b0, 2'd2, 16'h6000, 8'h00, 8'h5A, 1'b0, 1'b1},  // R1 mirror read
    {4'd2, 1'b1, 2'd2, 16'h6000, 8'h00, 8'hA5, 1'b0, 1'b1},  // R2 secondary open bus
    {4'd2, 1'b1, 2'd1, 16'h6000, 8'h77, 8'h77, 1'b0, 1'b1},  // R2 secondary write dropped
    {4'd5, 1'b1, 2'd1, 16'h4016, 8'h02, 8'h02, 1'b1, 1'b1},  // R5 secondary bit releases pri IRQ
    {4'd4, 1'b0, 2'd2, 16'h6000, 8'h00, 8'h5A, 1'b1, 1'b1},  // R4 ownership unchanged
    {4'd5, 1'b1, 2'd1, 16'h4016, 8'h00, 8'h00, 1'b0, 1'b1},  // R5 secondary asserts pri IRQ
    {4'd4, 1'b0, 2'd2, 16'h6000, 8'h00, 8'h5A, 1'b0, 1'b1},  // R4 still primary
    {4'd6, 1'b0, 2'd2, 16'h4016, 8'h00, 8'h00, 1'b0, 1'b1},  // R6 primary identity
    {4'd6, 1'b1, 2'd2, 16'h4016, 8'h00, 8'h80, 1'b0, 1'b1},  // R6 secondary identity
    {4'd3, 1'b0, 2'd1, 16'h4016, 8'h00, 8'h00, 1'b0, 1'b0},  // R3 hand back
    {4'd3, 1'b1, 2'd2, 16'h6000, 8'h00, 8'h5A, 1'b0, 1'b0}   // R3 secondary owns again
  };

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic idle();
    priWrEn = 1'b0; priRdEn = 1'b0; secWrEn = 1'b0; secRdEn = 1'b0;
  endtask

  // drive at a falling edge, clock in at the rising edge, sample at the next falling edge
  task automatic op(input logic port, input logic [1:0] kind, input logic [15:0] a,
                    input logic [7:0] d);
    if (port) begin
      secAddr = a; secWrData = d; secWrEn = (kind == 2'd1); secRdEn = (kind == 2'd2);
    end else begin
      priAddr = a; priWrData = d; priWrEn = (kind == 2'd1); priRdEn = (kind == 2'd2);
    end
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check8("R9 priRdData", priRdData, 8'h00);
    check8("R9 secRdData", secRdData, 8'h00);
    check1("R9 priIrqN", priIrqN, 1'b0);
    check1("R9 secIrqN", secIrqN, 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic [40:0] e;
      string tag;
      e = VEC[v];
      op(e[36], e[35:34], e[33:18], e[17:10]);
      tag = $sformatf("R%0d vec%0d", e[40:37], v);
      check8({tag, " rd"}, e[36] ? secRdData : priRdData, e[9:2]);
      check1({tag, " priIrqN"}, priIrqN, e[1]);
      check1({tag, " secIrqN"}, secIrqN, e[0]);
    end

    // R10 handover to primary in the same cycle as a secondary write: old owner wins
    priAddr = 16'h4016; priWrData = 8'h02; priWrEn = 1'b1;
    secAddr = 16'h6004; secWrData = 8'hC3; secWrEn = 1'b1;
    @(negedge clk); idle();
    check1("R10 secIrqN after handover", secIrqN, 1'b1);
    op(1'b0, 2'd2, 16'h6004, 8'h00);
    check8("R10 same-cycle sec write landed", priRdData, 8'hC3);

    // R10 handover to secondary in the same cycle as a secondary read: still open bus
    priAddr = 16'h4016; priWrData = 8'h00; priWrEn = 1'b1;
    secAddr = 16'h6000; secRdEn = 1'b1;
    @(negedge clk); idle();
    check8("R10 same-cycle sec read open bus", secRdData, 8'hC3);
    op(1'b1, 2'd2, 16'h6000, 8'h00);
    check8("R10 sec owns next cycle", secRdData, 8'h5A);

    // R7 strap overrides the primary bit
    op(1'b0, 2'd1, 16'h4016, 8'h02);
    check1("R7 pre-strap secIrqN", secIrqN, 1'b1);
    strapSolo = 1'b1;
    #1;
    check1("R7 strap secIrqN", secIrqN, 1'b0);
    @(negedge clk);
    op(1'b1, 2'd1, 16'h6008, 8'h99);
    op(1'b1, 2'd2, 16'h6008, 8'h00);
    check8("R7 secondary owns under strap", secRdData, 8'h99);
    op(1'b0, 2'd2, 16'h6008, 8'h00);
    check8("R7 primary open bus under strap", priRdData, 8'h02);
    strapSolo = 1'b0;
    @(negedge clk);
    check1("R7 strap released secIrqN", secIrqN, 1'b1);
    op(1'b0, 2'd2, 16'h6000, 8'h00);
    check8("R2 primary owns after strap", priRdData, 8'h5A);

    // R9 reset in mid-run
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check1("R9 mid reset secIrqN", secIrqN, 1'b0);
    check1("R9 mid reset priIrqN", priIrqN, 1'b0);
    check8("R9 mid reset priRdData", priRdData, 8'h00);
    op(1'b1, 2'd2, 16'h6008, 8'h00);
    check8("R9 secondary owns after reset", secRdData, 8'h99);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule